// File: doc/BRIEF.md
# Lockable Write-Back Set-Associative Data Cache

This block is a four-way set-associative data cache that works in copy-back mode. Any line can be pinned with a lock command and released with an unlock command. A processor-side request channel takes one command at a time: load, store, lock, unlock or invalidate. Each command carries a 32-bit byte address and a 32-bit word. A memory-side channel moves single words. It is used for line refills, for writebacks of dirty victims, and for word-sized accesses that bypass the cache.

A locked line is never picked as a victim. When every way of a set is valid and locked, a load or store that misses there goes straight to memory as one word and allocates nothing. Invalidating a line throws it away and does not write it back, even when it holds dirty data. By default the cache has 256 sets of 32-byte lines, so the set index repeats every 8 KiB. The geometry is set by parameters, so a bench can use a much smaller cache.

The request channel follows valid/ready rules. A command is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the command's response. Each command gets exactly one single-cycle `rsp_valid` pulse. The response channel has no back-pressure, so the requester must always take it. On the memory channel, `mem_valid` with its address, direction and write data is held steady until the edge on which `mem_ready` is high. Read data on `mem_rdata` is taken on that same edge.

Top module: `dcache_lockable`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_valid` are 0, and every line is invalid, so the first access to any line misses.
- R2: Command codes on `req_cmd` are: 0 load, 1 store, 2 lock, 3 unlock, 4 invalidate. Codes 5 to 7 complete with no effect. After a command is accepted, `req_ready` is 0 until its response. `rsp_valid` is a single-cycle pulse, one per command.
- R3: A load that misses with an unlocked way free reads the whole line (2^WOFF_W words) from memory and returns the addressed word. A load that hits returns the cached word and causes no memory traffic.
- R4: A store that hits updates only the cached word and marks the line dirty. It causes no memory write.
- R5: Before a dirty victim is refilled, all of its words are written back. Every writeback write comes before the first refill read.
- R6: A lock command fetches the line if it is absent and then sets its lock bit. A locked line is never evicted by a later miss.
- R7: A store that misses in a set whose ways are all valid and locked writes one word directly to memory, with no refill and no allocation.
- R8: A load that misses in a fully locked set reads one word from memory and does not allocate, so repeating the load reads memory again.
- R9: Invalidate clears the matching line without a writeback. A later load returns what memory holds.
- R10: Unlock clears only the lock bit and keeps the data, including dirty data. Unlock or invalidate of an address that is not resident has no effect and causes no memory traffic.
- R11: The victim is the lowest-numbered invalid way. If there is none, a per-set round-robin pointer picks the first unlocked way at or after it. After each fill, the pointer moves to the way after the one just filled.
- R12: A lock command that misses in a fully locked set does nothing and causes no memory traffic.
- R13: While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Cache can take a command |
| req_cmd | input | 3 | Command code (see R2) |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store word |
| rsp_valid | output | 1 | Command finished (one-cycle pulse) |
| rsp_rdata | output | DATA_W | Load result, zero for other commands |
| mem_valid | output | 1 | Memory word request |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | DATA_W | Write word |
| mem_rdata | input | DATA_W | Read word, valid with mem_ready |

## Verification
The bench targets the set that fills up completely with locked lines. A design that still allocated there would show refill reads on a bypassed store, and its second identical bypassed load would hit when it should go to memory. The bench unlocks one dirty way and forces a miss into that set. If the cache evicted a locked way, or skipped the writeback, the stored value would not come back and the memory word would keep its old contents. The bench also checks invalidation of dirty lines, where wrongly writing them back would change memory. It checks unlock and invalidate on absent addresses, and the round-robin pointer stepping past a locked way, where a first-unlocked policy would evict the line just filled.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  typedef enum logic [2:0] {
    CMD_LOAD   = 3'd0,
    CMD_STORE  = 3'd1,
    CMD_LOCK   = 3'd2,
    CMD_UNLOCK = 3'd3,
    CMD_INVAL  = 3'd4
  } dc_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB,
    ST_FILL,
    ST_BYP_RD,
    ST_BYP_WR
  } dc_state_e;
endpackage

// File: rtl/dcache_data_way.sv
module dcache_data_way #(
  parameter int AW     = 11,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     ad,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[ad] <= wdata;
  end

  assign rdata = mem_q[ad];
endmodule

// File: rtl/dcache_tag_store.sv
module dcache_tag_store #(
  parameter int WAYS  = 4,
  parameter int IDX_W = 8,
  parameter int TAG_W = 19
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            idx,
  input  logic [TAG_W-1:0]            look_tag,
  input  logic                        inst_en,
  input  logic [$clog2(WAYS)-1:0]     inst_way,
  input  logic                        dirty_set,
  input  logic                        lock_set,
  input  logic                        lock_clr,
  input  logic                        inval_en,
  input  logic [$clog2(WAYS)-1:0]     op_way,
  output logic [WAYS-1:0]             hit_vec,
  output logic [WAYS-1:0]             valid_vec,
  output logic [WAYS-1:0]             dirty_vec,
  output logic [WAYS-1:0]             lock_vec,
  output logic [WAYS-1:0][TAG_W-1:0]  way_tag
);
  localparam int SETS = 1 << IDX_W;

  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAYS-1:0]  drt_q [SETS];
  logic [WAYS-1:0]  lck_q [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        drt_q[s] <= '0;
        lck_q[s] <= '0;
      end
    end else begin
      if (inst_en) begin
        vld_q[idx][inst_way] <= 1'b1;
        drt_q[idx][inst_way] <= 1'b0;
        lck_q[idx][inst_way] <= 1'b0;
      end
      if (inval_en) begin
        vld_q[idx][op_way] <= 1'b0;
        drt_q[idx][op_way] <= 1'b0;
        lck_q[idx][op_way] <= 1'b0;
      end
      if (dirty_set) drt_q[idx][op_way] <= 1'b1;
      if (lock_set)  lck_q[idx][op_way] <= 1'b1;
      if (lock_clr)  lck_q[idx][op_way] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (inst_en) tag_q[idx][inst_way] <= look_tag;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = vld_q[idx][w] && (tag_q[idx][w] == look_tag);
    assign way_tag[w] = tag_q[idx][w];
  end

  assign valid_vec = vld_q[idx];
  assign dirty_vec = drt_q[idx];
  assign lock_vec  = lck_q[idx];

  // R6: a fill never lands on a pinned way
  p_no_evict_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inst_en |-> !lck_q[idx][inst_way]);

  // R3: a tag appears at most once per set
  p_hit_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/dcache_victim.sv
module dcache_victim #(
  parameter int WAYS  = 4,
  parameter int IDX_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [IDX_W-1:0]        idx,
  input  logic [WAYS-1:0]         valid_vec,
  input  logic [WAYS-1:0]         lock_vec,
  input  logic                    adv_en,
  input  logic [$clog2(WAYS)-1:0] adv_way,
  output logic [$clog2(WAYS)-1:0] victim,
  output logic                    set_full
);
  localparam int SETS  = 1 << IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  logic [WAY_W-1:0] ptr_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (adv_en) begin
      ptr_q[idx] <= adv_way + WAY_W'(1);
    end
  end

  assign set_full = &(valid_vec & lock_vec);

  always_comb begin
    logic             found;
    logic [WAY_W-1:0] cand;
    found  = 1'b0;
    victim = '0;
    cand   = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (!found && !valid_vec[i]) begin
        victim = WAY_W'(i);
        found  = 1'b1;
      end
    end
    for (int k = 0; k < WAYS; k++) begin
      cand = ptr_q[idx] + WAY_W'(k);
      if (!found && !lock_vec[cand]) begin
        victim = cand;
        found  = 1'b1;
      end
    end
  end

  // R11: with a free way in the set the choice is never a pinned way
  p_victim_unlocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !set_full |-> !lock_vec[victim]);
endmodule

// File: rtl/dcache_lockable.sv
module dcache_lockable
  import dcache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WAYS   = 4,
  parameter int IDX_W  = 8,
  parameter int WOFF_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int BOFF_W = $clog2(DATA_W / 8);
  localparam int TAG_W  = ADDR_W - IDX_W - WOFF_W - BOFF_W;
  localparam int WAY_W  = $clog2(WAYS);
  localparam int RAM_AW = IDX_W + WOFF_W;

  dc_state_e         state_q, st_d;
  dc_cmd_e           cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [WOFF_W-1:0] beat_q;
  logic [WAY_W-1:0]  vic_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [WOFF_W-1:0] word;

  assign idx  = addr_q[BOFF_W + WOFF_W +: IDX_W];
  assign tag  = addr_q[ADDR_W-1 -: TAG_W];
  assign word = addr_q[BOFF_W +: WOFF_W];

  logic [WAYS-1:0]            hit_vec, valid_vec, dirty_vec, lock_vec;
  logic [WAYS-1:0][TAG_W-1:0] way_tag;
  logic [WAY_W-1:0]           victim, hit_way;
  logic                       set_full, hit, last_beat;

  logic fin, store_we, fill_we, beat_inc, go_miss, inst;
  logic dirty_set, lock_set, lock_clr, inval;
  logic [DATA_W-1:0] rdata_d;

  logic [DATA_W-1:0] way_rd [WAYS];
  logic [WAYS-1:0]   way_we;
  logic [WOFF_W-1:0] ram_word;
  logic [DATA_W-1:0] ram_wdata;

  always_comb begin
    hit_way = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (hit_vec[i]) hit_way = WAY_W'(i);
    end
  end
  assign hit       = |hit_vec;
  assign last_beat = (beat_q == '1);

  dcache_tag_store #(.WAYS(WAYS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx       (idx),
    .look_tag  (tag),
    .inst_en   (inst),
    .inst_way  (vic_q),
    .dirty_set (dirty_set),
    .lock_set  (lock_set),
    .lock_clr  (lock_clr),
    .inval_en  (inval),
    .op_way    (hit_way),
    .hit_vec   (hit_vec),
    .valid_vec (valid_vec),
    .dirty_vec (dirty_vec),
    .lock_vec  (lock_vec),
    .way_tag   (way_tag)
  );

  dcache_victim #(.WAYS(WAYS), .IDX_W(IDX_W)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx       (idx),
    .valid_vec (valid_vec),
    .lock_vec  (lock_vec),
    .adv_en    (inst),
    .adv_way   (vic_q),
    .victim    (victim),
    .set_full  (set_full)
  );

  assign ram_word  = (state_q == ST_WB || state_q == ST_FILL) ? beat_q : word;
  assign ram_wdata = (state_q == ST_FILL) ? mem_rdata : wdata_q;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_we[w] = (store_we && hit_way == WAY_W'(w)) ||
                       (fill_we && vic_q == WAY_W'(w));
    dcache_data_way #(.AW(RAM_AW), .DATA_W(DATA_W)) u_data (
      .clk   (clk),
      .we    (way_we[w]),
      .ad    ({idx, ram_word}),
      .wdata (ram_wdata),
      .rdata (way_rd[w])
    );
  end

  always_comb begin
    st_d      = state_q;
    fin       = 1'b0;
    rdata_d   = '0;
    store_we  = 1'b0;
    fill_we   = 1'b0;
    beat_inc  = 1'b0;
    go_miss   = 1'b0;
    inst      = 1'b0;
    dirty_set = 1'b0;
    lock_set  = 1'b0;
    lock_clr  = 1'b0;
    inval     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid) st_d = ST_LOOK;
      ST_LOOK: begin
        if (hit) begin
          fin = 1'b1;
          case (cmd_q)
            CMD_LOAD:   rdata_d = way_rd[hit_way];
            CMD_STORE:  begin store_we = 1'b1; dirty_set = 1'b1; end
            CMD_LOCK:   lock_set = 1'b1;
            CMD_UNLOCK: lock_clr = 1'b1;
            CMD_INVAL:  inval = 1'b1;
            default:    ;
          endcase
        end else if (!(cmd_q inside {CMD_LOAD, CMD_STORE, CMD_LOCK})) begin
          fin = 1'b1;
        end else if (set_full) begin
          if (cmd_q == CMD_LOAD)       st_d = ST_BYP_RD;
          else if (cmd_q == CMD_STORE) st_d = ST_BYP_WR;
          else                         fin = 1'b1;
        end else begin
          go_miss = 1'b1;
          st_d = (valid_vec[victim] && dirty_vec[victim]) ? ST_WB : ST_FILL;
        end
        if (fin) st_d = ST_IDLE;
      end
      ST_WB: if (mem_ready) begin
        beat_inc = 1'b1;
        if (last_beat) st_d = ST_FILL;
      end
      ST_FILL: if (mem_ready) begin
        fill_we  = 1'b1;
        beat_inc = 1'b1;
        if (last_beat) begin
          inst = 1'b1;
          st_d = ST_LOOK;
        end
      end
      ST_BYP_RD: if (mem_ready) begin
        fin     = 1'b1;
        rdata_d = mem_rdata;
        st_d    = ST_IDLE;
      end
      ST_BYP_WR: if (mem_ready) begin
        fin  = 1'b1;
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cmd_q       <= CMD_LOAD;
      addr_q      <= '0;
      wdata_q     <= '0;
      beat_q      <= '0;
      vic_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      state_q     <= st_d;
      rsp_valid_q <= fin;
      if (fin) rsp_rdata_q <= rdata_d;
      if (state_q == ST_IDLE && req_valid) begin
        cmd_q   <= dc_cmd_e'(req_cmd);
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (go_miss) begin
        vic_q  <= victim;
        beat_q <= '0;
      end else if (beat_inc) begin
        beat_q <= beat_q + WOFF_W'(1);
      end
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state_q)
      ST_WB: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {way_tag[vic_q], idx, beat_q, {BOFF_W{1'b0}}};
        mem_wdata = way_rd[vic_q];
      end
      ST_FILL: begin
        mem_valid = 1'b1;
        mem_addr  = {tag, idx, beat_q, {BOFF_W{1'b0}}};
      end
      ST_BYP_RD: begin
        mem_valid = 1'b1;
        mem_addr  = {addr_q[ADDR_W-1:BOFF_W], {BOFF_W{1'b0}}};
      end
      ST_BYP_WR: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {addr_q[ADDR_W-1:BOFF_W], {BOFF_W{1'b0}}};
        mem_wdata = wdata_q;
      end
      default: ;
    endcase
  end

  p_one_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_mem_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

  p_bypass_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BYP_WR || state_q == ST_BYP_RD) |-> set_full);
endmodule

// File: tb/dcache_lockable_test.sv
`timescale 1ns/1ps
module dcache_lockable_test;
  localparam int IDX_W  = 2;
  localparam int WOFF_W = 1;
  localparam logic [2:0] C_LD = 3'd0, C_ST = 3'd1, C_LK = 3'd2, C_UL = 3'd3, C_IV = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_cmd = '0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        mem_valid, mem_ready, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  dcache_lockable #(.IDX_W(IDX_W), .WOFF_W(WOFF_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model: ready every other cycle while a request is pending
  logic [31:0] mem [1024];
  logic        rdy_q = 1'b0;
  always @(posedge clk) begin
    rdy_q <= rst_n && mem_valid && !rdy_q;
    if (mem_valid && mem_ready && mem_we) mem[mem_addr[11:2]] <= mem_wdata;
  end
  assign mem_ready = rdy_q;
  assign mem_rdata = mem[mem_addr[11:2]];

  // traffic monitor
  int n_rd = 0, n_wr = 0, n_viol = 0, n_hold = 0;
  logic rd_seen = 1'b0, pend = 1'b0, p_we = 1'b0;
  logic [31:0] p_addr = '0, p_wd = '0;
  always @(posedge clk) begin
    if (req_valid && req_ready) rd_seen <= 1'b0;
    if (mem_valid && mem_ready) begin
      if (mem_we) begin
        n_wr <= n_wr + 1;
        if (rd_seen) n_viol <= n_viol + 1;
      end else begin
        n_rd <= n_rd + 1;
        rd_seen <= 1'b1;
      end
    end
    if (pend && (!mem_valid || mem_addr != p_addr || mem_we != p_we || mem_wdata != p_wd))
      n_hold <= n_hold + 1;
    pend   <= mem_valid && !mem_ready;
    p_addr <= mem_addr;
    p_we   <= mem_we;
    p_wd   <= mem_wdata;
  end

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] r;
  int drd, dwr, dvi;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return 32'hA500_0000 + a;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int i = 0; i < 1024; i++) mem[i] = pat(32'(i) << 2);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cmd(input logic [2:0] c, input logic [31:0] a, input logic [31:0] d,
                     input bit hs);
    int rd0, wr0, vi0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    rd0 = n_rd; wr0 = n_wr; vi0 = n_viol;
    req_valid = 1'b1; req_cmd = c; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (hs) chk("R2 ready low while busy", 32'(req_ready), 32'd0);
    while (!rsp_valid) @(negedge clk);
    r = rsp_rdata;
    drd = n_rd - rd0; dwr = n_wr - wr0; dvi = n_viol - vi0;
    if (hs) begin
      @(negedge clk);
      chk("R2 single response pulse", 32'(rsp_valid), 32'd0);
    end
  endtask

  localparam logic [31:0] A = 32'h100;   // set 0, lines 32 bytes apart share it
  localparam logic [31:0] B = 32'h010;   // set 2

  initial begin
    do_reset();
    // R1
    chk("R1 ready", 32'(req_ready), 32'd1);
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 mem_valid", 32'(mem_valid), 32'd0);
    cmd(C_LD, 32'h0, 0, 1'b1);
    chk("R1 first access misses", 32'(drd), 32'd2);
    chk("R3 miss data", r, pat(32'h0));

    // R3: sweep 16 lines (4 per set, fits exactly), then all hit
    for (int a = 4; a < 32'h80; a += 4) begin
      cmd(C_LD, 32'(a), 0, 1'b0);
      chk("R3 sweep data", r, pat(32'(a)));
      chk("R3 sweep reads", 32'(drd), (a % 8 == 0) ? 32'd2 : 32'd0);
    end
    for (int a = 0; a < 32'h80; a += 4) begin
      cmd(C_LD, 32'(a), 0, 1'b0);
      chk("R3 hit no traffic", 32'(drd + dwr), 32'd0);
    end
    // R4: store hits stay in cache
    for (int a = 0; a < 32'h80; a += 4) begin
      cmd(C_ST, 32'(a), ~pat(32'(a)), 1'b0);
      chk("R4 store hit no write", 32'(dwr), 32'd0);
      chk("R4 memory untouched", mem[a >> 2], pat(32'(a)));
      cmd(C_LD, 32'(a), 0, 1'b0);
      chk("R4 readback", r, ~pat(32'(a)));
    end
    // R5: evicting every dirty line
    for (int a = 32'h80; a < 32'h100; a += 8) begin
      cmd(C_LD, 32'(a), 0, 1'b0);
      chk("R5 writeback words", 32'(dwr), 32'd2);
      chk("R5 refill words", 32'(drd), 32'd2);
      chk("R5 writes before reads", 32'(dvi), 32'd0);
      chk("R5 memory updated", mem[(a - 32'h80) >> 2], ~pat(32'(a - 32'h80)));
      chk("R3 data after evict", r, pat(32'(a)));
    end

    // lock scenario
    do_reset();
    for (int k = 0; k < 4; k++) begin
      cmd(C_LK, A + 32'(32 * k), 0, 1'b0);
      chk("R6 lock fetches line", 32'(drd), 32'd2);
      cmd(C_ST, A + 32'(32 * k), 32'h1111_1111 * 32'(k + 1), 1'b0);
      chk("R6 store hits locked line", 32'(dwr + drd), 32'd0);
    end
    chk("R4 locked store not in memory", mem[A >> 2], pat(A));
    cmd(C_ST, A + 128, 32'hDEAD_BEEF, 1'b0);
    chk("R7 bypass single write", 32'(dwr), 32'd1);
    chk("R7 bypass no refill", 32'(drd), 32'd0);
    chk("R7 memory written", mem[(A + 128) >> 2], 32'hDEAD_BEEF);
    cmd(C_LD, A + 160, 0, 1'b0);
    chk("R8 bypass read data", r, pat(A + 160));
    chk("R8 bypass one read", 32'(drd), 32'd1);
    cmd(C_LD, A + 160, 0, 1'b0);
    chk("R8 no allocation", 32'(drd), 32'd1);
    cmd(C_LK, A + 192, 0, 1'b0);
    chk("R12 lock in full set idle", 32'(drd + dwr), 32'd0);
    cmd(C_ST, A + 192, 32'h7777_0000, 1'b0);
    chk("R12 line not allocated", 32'(dwr), 32'd1);
    for (int k = 0; k < 4; k++) begin
      cmd(C_IV, A + 32'(32 * k), 0, 1'b0);
      chk("R9 invalidate no writeback", 32'(dwr), 32'd0);
    end
    for (int k = 0; k < 4; k++) begin
      cmd(C_LD, A + 32'(32 * k), 0, 1'b0);
      chk("R9 old memory value", r, pat(A + 32'(32 * k)));
    end
    cmd(C_LD, A + 128, 0, 1'b0);
    chk("R7 bypassed value readable", r, 32'hDEAD_BEEF);

    // unlock scenario
    do_reset();
    for (int k = 0; k < 4; k++) begin
      cmd(C_LK, A + 32'(32 * k), 0, 1'b0);
      cmd(C_ST, A + 32'(32 * k), 32'h1111_1111 * 32'(k + 1), 1'b0);
    end
    cmd(C_UL, A + 64, 0, 1'b0);
    chk("R10 unlock no traffic", 32'(drd + dwr), 32'd0);
    cmd(C_ST, A + 160, 32'hBEEF_DEAD, 1'b0);
    chk("R10 dirty unlocked line written back", 32'(dwr), 32'd2);
    chk("R10 kept data reaches memory", mem[(A + 64) >> 2], 32'h3333_3333);
    chk("R6 refill into freed way", 32'(drd), 32'd2);
    for (int k = 0; k < 4; k++) begin
      if (k != 2) begin
        cmd(C_LD, A + 32'(32 * k), 0, 1'b0);
        chk("R6 locked line survives", r, 32'h1111_1111 * 32'(k + 1));
        chk("R6 locked line hits", 32'(drd), 32'd0);
      end
    end
    cmd(C_LD, A + 64, 0, 1'b0);
    chk("R10 unlocked value readable", r, 32'h3333_3333);
    cmd(C_LD, A + 160, 0, 1'b0);
    chk("R10 new value readable", r, 32'hBEEF_DEAD);
    cmd(C_LK, A + 160, 0, 1'b0);
    chk("R6 lock hit no traffic", 32'(drd + dwr), 32'd0);
    cmd(C_UL, A + 224, 0, 1'b0);
    chk("R10 absent unlock idle", 32'(drd + dwr), 32'd0);
    cmd(C_ST, A + 224, 32'h0BAD_F00D, 1'b0);
    chk("R10 absent unlock left set full", 32'(dwr), 32'd1);
    chk("R7 bypass write value", mem[(A + 224) >> 2], 32'h0BAD_F00D);
    cmd(C_IV, A + 192, 0, 1'b0);
    chk("R10 absent invalidate idle", 32'(drd + dwr), 32'd0);
    cmd(C_LD, A, 0, 1'b0);
    chk("R10 resident line unaffected", r, 32'h1111_1111);
    chk("R10 resident line hits", 32'(drd), 32'd0);

    // round robin
    do_reset();
    for (int i = 0; i < 4; i++) begin
      cmd(C_LD, B + 32'(32 * i), 0, 1'b0);
      chk("R11 invalid ways fill first", 32'(drd), 32'd2);
    end
    cmd(C_LK, B + 32, 0, 1'b0);
    cmd(C_LD, B + 128, 0, 1'b0);
    cmd(C_LD, B + 160, 0, 1'b0);
    cmd(C_LD, B + 96, 0, 1'b0);
    chk("R11 way3 kept", 32'(drd), 32'd0);
    cmd(C_LD, B + 32, 0, 1'b0);
    chk("R11 locked way kept", 32'(drd), 32'd0);
    cmd(C_LD, B + 128, 0, 1'b0);
    chk("R11 pointer advanced past fill", 32'(drd), 32'd0);
    cmd(C_LD, B + 160, 0, 1'b0);
    chk("R11 second fill resident", 32'(drd), 32'd0);
    chk("R11 data", r, pat(B + 160));
    cmd(C_LD, B + 64, 0, 1'b0);
    chk("R11 way2 was the victim", 32'(drd), 32'd2);

    cmd(3'd6, A, 32'h1234, 1'b1);
    chk("R2 unused code no traffic", 32'(drd + dwr), 32'd0);
    chk("R13 request held until ready", 32'(n_hold), 32'd0);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule